// File: doc/BRIEF.md
# Dual-Stream Uniform Coordinate Generator

This block produces one pair of pseudo-random coordinates on each enabled clock, as raw material for Monte Carlo sampling such as a quarter-circle hit test. Two 32-bit linear congruential recurrences run side by side. The horizontal stream and the vertical stream use different multiplier and increment constants, so that points built from the two streams do not fall on a shared lattice of hyperplanes.

Each stream's state goes to its output in two forms, and no integer-to-float converter is used for either. The first form is an IEEE-754 single-precision word in [1.0, 2.0): the top 23 state bits become the mantissa, under sign 0 and biased exponent 127. The second form is the same 23 bits read as an unsigned fraction of 2^23, which equals the packed value minus 1.0. A seed port loads both states in one cycle. An enable advances both streams together, and a valid flag marks the cycles in which a fresh pair is shown.

Top module: `dual_lcg_uniform`

## Requirements
- R1: While `rst` is high, `valid` is 0. After reset the horizontal state is 32'h0000_0001 and the vertical state is 32'h2545_F491, and the outputs show these states.
- R2: On each advancing cycle the horizontal state becomes (1664525 * s + 1013904223) mod 2^32.
- R3: On each advancing cycle the vertical state becomes (1103515245 * s + 12345) mod 2^32.
- R4: `x_bits` and `y_bits` always equal {1'b0, 8'd127, state[31:9]} of their own stream: sign bit 31, exponent bits 30:23, mantissa bits 22:0.
- R5: `x_frac` and `y_frac` always equal state[31:9] of their own stream, so the coordinate value is frac / 2^23.
- R6: A cycle with `en` high and `load` low advances both streams. In the next cycle `valid` is 1 and the outputs show the new states. A cycle with `en` low and `load` low leaves both states unchanged, and in the next cycle `valid` is 0.
- R7: A cycle with `load` high puts `seed_x` and `seed_y` into the states whatever `en` is. In the next cycle `valid` is 0 and the outputs show the seeds. The first valid pair after a load is one step past the seeds.
- R8: A seed of zero is legal. From seed 0 the first horizontal state is 1013904223, the first vertical state is 12345, and an all-ones seed wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load both seeds this cycle |
| seed_x | input | 32 | Seed for the horizontal stream |
| seed_y | input | 32 | Seed for the vertical stream |
| en | input | 1 | Advance both streams this cycle |
| valid | output | 1 | A fresh coordinate pair is shown |
| x_bits | output | 32 | Horizontal coordinate as a single in [1.0, 2.0) |
| y_bits | output | 32 | Vertical coordinate as a single in [1.0, 2.0) |
| x_frac | output | 23 | Horizontal coordinate as a fraction of 2^23 |
| y_frac | output | 23 | Vertical coordinate as a fraction of 2^23 |

## Verification
The first pattern is a long unbroken run of enables from the reset seeds. Comparing both recurrences over many steps shows whether either stream has its constants swapped with the other's or lost a carry in the multiply. The second pattern mixes in idle cycles. It shows whether a held state is truly held and whether `valid` drops on the right cycle, rather than the stream advancing without being shown. The third pattern loads seeds of zero, all ones and mixed values, some with `en` high in the same cycle. It shows whether a load takes priority over a step and whether the first valid pair lies exactly one step past the seed.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

    localparam int STATE_W = 32;
    localparam int MANT_W  = 23;
    localparam int EXP_W   = 8;
    localparam int DROP_W  = STATE_W - MANT_W;
    localparam int LANES   = 2;

    typedef logic [STATE_W-1:0] state_t;
    typedef logic [MANT_W-1:0]  frac_t;

    typedef enum logic [0:0] {
        FAM_HORZ = 1'b0,
        FAM_VERT = 1'b1
    } lcg_family_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exponent;
        frac_t            mantissa;
    } f32_t;

    localparam logic [EXP_W-1:0] UNIT_EXP = 8'd127;

    localparam state_t HORZ_MUL = 32'd1664525;
    localparam state_t HORZ_INC = 32'd1013904223;
    localparam state_t VERT_MUL = 32'd1103515245;
    localparam state_t VERT_INC = 32'd12345;

    localparam state_t HORZ_RESET_SEED = 32'h0000_0001;
    localparam state_t VERT_RESET_SEED = 32'h2545_F491;

    function automatic state_t family_mul(lcg_family_e fam);
        return (fam == FAM_HORZ) ? HORZ_MUL : VERT_MUL;
    endfunction

    function automatic state_t family_inc(lcg_family_e fam);
        return (fam == FAM_HORZ) ? HORZ_INC : VERT_INC;
    endfunction

    function automatic state_t family_seed(lcg_family_e fam);
        return (fam == FAM_HORZ) ? HORZ_RESET_SEED : VERT_RESET_SEED;
    endfunction

    function automatic frac_t top_fraction(state_t s);
        return s[STATE_W-1:DROP_W];
    endfunction

endpackage

// File: rtl/lcg_stream.sv
module lcg_stream
    import lcg_pkg::*;
#(
    parameter lcg_family_e FAMILY = FAM_HORZ
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  state_t seed,
    input  logic   step,
    output state_t state
);
    localparam state_t MUL  = family_mul(FAMILY);
    localparam state_t INC  = family_inc(FAMILY);
    localparam state_t INIT = family_seed(FAMILY);

    state_t state_q;
    state_t next_state;

    // One multiply and one add; the product is truncated to the state width.
    always_comb begin
        next_state = MUL * state_q + INC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= INIT;
        end else if (load) begin
            state_q <= seed;
        end else if (step) begin
            state_q <= next_state;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/unit_pack.sv
module unit_pack
    import lcg_pkg::*;
(
    input  frac_t  top_bits,
    output logic [STATE_W-1:0] packed_word,
    output frac_t  frac
);
    f32_t word;

    always_comb begin
        word.sign     = 1'b0;
        word.exponent = UNIT_EXP;
        word.mantissa = top_bits;
    end

    assign packed_word = word;
    assign frac        = top_bits;

endmodule

// File: rtl/dual_lcg_uniform.sv
module dual_lcg_uniform
    import lcg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] seed_x,
    input  logic [31:0] seed_y,
    input  logic        en,
    output logic        valid,
    output logic [31:0] x_bits,
    output logic [31:0] y_bits,
    output logic [22:0] x_frac,
    output logic [22:0] y_frac
);
    state_t seeds  [LANES];
    state_t states [LANES];
    logic [STATE_W-1:0] words [LANES];
    frac_t  fracs  [LANES];
    logic   valid_q;

    assign seeds[0] = seed_x;
    assign seeds[1] = seed_y;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            localparam lcg_family_e FAM = lcg_family_e'(g);

            lcg_stream #(
                .FAMILY(FAM)
            ) u_stream (
                .clk  (clk),
                .rst  (rst),
                .load (load),
                .seed (seeds[g]),
                .step (en),
                .state(states[g])
            );

            unit_pack u_pack (
                .top_bits   (top_fraction(states[g])),
                .packed_word(words[g]),
                .frac       (fracs[g])
            );
        end
    endgenerate

    // Valid marks the cycle after a step, aligned with the state register.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= en & ~load;
        end
    end

    assign valid  = valid_q;
    assign x_bits = words[0];
    assign y_bits = words[1];
    assign x_frac = fracs[0];
    assign y_frac = fracs[1];

endmodule

// File: rtl/dual_lcg_uniform_chk.sv
module dual_lcg_uniform_chk (
    input logic        clk,
    input logic        rst,
    input logic        load,
    input logic [31:0] seed_x,
    input logic [31:0] seed_y,
    input logic        en,
    input logic        valid,
    input logic [31:0] x_bits,
    input logic [31:0] y_bits,
    input logic [22:0] x_frac,
    input logic [22:0] y_frac
);
    assert_valid_after_step_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> valid);

    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> (!valid && $stable(x_bits) && $stable(y_bits)));

    assert_load_shows_seed_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (!valid && x_frac == $past(seed_x[31:9]) && y_frac == $past(seed_y[31:9])));

    assert_packing_matches_frac_R4: assert property (@(posedge clk) disable iff (rst)
        (x_bits == {9'h07F, x_frac}) && (y_bits == {9'h07F, y_frac}));

    assert_reset_clears_valid_R1: assert property (@(posedge clk)
        rst |=> !valid);
endmodule

bind dual_lcg_uniform dual_lcg_uniform_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .seed_x(seed_x),
    .seed_y(seed_y),
    .en    (en),
    .valid (valid),
    .x_bits(x_bits),
    .y_bits(y_bits),
    .x_frac(x_frac),
    .y_frac(y_frac)
);

// File: tb/tb_dual_lcg_uniform.sv
module tb_dual_lcg_uniform;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [31:0] seed_x = '0;
    logic [31:0] seed_y = '0;
    logic        en = 1'b0;
    logic        valid;
    logic [31:0] x_bits, y_bits;
    logic [22:0] x_frac, y_frac;

    int applied = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [31:0] mx, my;
    logic        mvalid;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_lcg_uniform dut (
        .clk(clk), .rst(rst), .load(load), .seed_x(seed_x), .seed_y(seed_y),
        .en(en), .valid(valid), .x_bits(x_bits), .y_bits(y_bits),
        .x_frac(x_frac), .y_frac(y_frac)
    );

    function automatic logic [31:0] next_horz(logic [31:0] s);
        longint unsigned p;
        p = (64'd1664525 * {32'd0, s} + 64'd1013904223) % 64'h1_0000_0000;
        return p[31:0];
    endfunction

    function automatic logic [31:0] next_vert(logic [31:0] s);
        longint unsigned p;
        p = (64'd1103515245 * {32'd0, s} + 64'd12345) % 64'h1_0000_0000;
        return p[31:0];
    endfunction

    task automatic check(string tag, logic [31:0] actual, logic [31:0] expected);
        applied++;
        if (actual !== expected) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, actual, expected);
        end
    endtask

    // Compare all outputs against the model; sampled at the falling edge.
    task automatic check_all(string tag);
        check({tag, " valid R6"}, {31'd0, valid}, {31'd0, mvalid});
        check({tag, " x_frac R2 R5"}, {9'd0, x_frac}, {9'd0, mx[31:9]});
        check({tag, " y_frac R3 R5"}, {9'd0, y_frac}, {9'd0, my[31:9]});
        check({tag, " x_bits R4"}, x_bits, {1'b0, 8'd127, mx[31:9]});
        check({tag, " y_bits R4"}, y_bits, {1'b0, 8'd127, my[31:9]});
    endtask

    // Drive one cycle at a falling edge, update the model, check at the next one.
    task automatic cycle(string tag, logic en_i, logic load_i, logic [31:0] sx, logic [31:0] sy);
        en = en_i; load = load_i; seed_x = sx; seed_y = sy;
        if (load_i) begin
            mx = sx; my = sy; mvalid = 1'b0;
        end else if (en_i) begin
            mx = next_horz(mx); my = next_vert(my); mvalid = 1'b1;
        end else begin
            mvalid = 1'b0;
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("reset valid R1", {31'd0, valid}, 32'd0);
        rst = 1'b0;
        mx = 32'h0000_0001; my = 32'h2545_F491; mvalid = 1'b0;
        @(negedge clk);
        check_all("after reset R1");

        // Long unbroken run from the reset seeds.
        for (int i = 0; i < 2000; i++) cycle("run R2 R3", 1'b1, 1'b0, '0, '0);

        // Idle cycles interleaved with steps.
        for (int i = 0; i < 600; i++) cycle("gap R6", (i % 3) == 0, 1'b0, '0, '0);

        // Zero seed corner (R8).
        cycle("load zero R7", 1'b0, 1'b1, 32'd0, 32'd0);
        cycle("zero step R8", 1'b1, 1'b0, '0, '0);
        check("zero x R8", mx, 32'd1013904223);
        check("zero y R8", my, 32'd12345);

        // All-ones seed, loaded with enable high: load wins (R7, R8).
        cycle("load ones R7", 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        cycle("ones step R8", 1'b1, 1'b0, '0, '0);

        // Sweep of seeds with load/enable mixes.
        for (int k = 0; k < 256; k++) begin
            logic [31:0] sx, sy;
            sx = 32'h9E37_79B9 * k[31:0] + 32'd7;
            sy = {k[7:0], ~k[7:0], k[7:0], 8'hA5};
            cycle("seed sweep R7", k[0], 1'b1, sx, sy);
            for (int j = 0; j < 8; j++)
                cycle("sweep steps R2 R3", (j % 4) != 3, 1'b0, '0, '0);
        end

        // Back-to-back loads keep valid low.
        cycle("reload a R7", 1'b1, 1'b1, 32'h1234_5678, 32'h8765_4321);
        cycle("reload b R7", 1'b1, 1'b1, 32'hDEAD_BEEF, 32'h0BAD_F00D);
        cycle("reload step R7", 1'b1, 1'b0, '0, '0);

        summary();
    end
endmodule